// File: doc/BRIEF.md
# Serial EEPROM Access Sequencer

This block carries out the memory side of a byte-wide two-wire serial EEPROM. A bus slave front end handles the wire protocol: it detects start and stop, matches the device address and sends the acknowledge bits. It passes this block one pulse per device-select byte, with the read/write bit, and one pulse per stop. Write-side bytes travel over a valid/ready stream into the block, and read-side bytes travel over a valid/ready stream out of it.

After a write-mode select, two address bytes load a persistent address counter. Data bytes then go into a page buffer, at offsets that wrap inside the current page. A stop that ends a transfer holding data starts a timed internal write cycle, and the buffered bytes are copied into the array during that cycle. A read-mode select streams bytes from the counter onward, wrapping across the whole array.

A write-protect input lets every byte through the handshake but keeps the array unchanged. The array size and the write-cycle length are parameters. The default is a reduced array, and the full 16,384-byte part uses `AW = 14`.

Top module: `eep_seq`

## Requirements
- R1: After reset, `busy_o`, `in_ready_o` and `out_valid_o` are low and the address counter is 0, so the first read-mode select with no address streams from address 0.
- R2: A write-mode select (`sel_i` with `sel_rd_i` = 0) is followed by two address bytes, high byte first. The address is the low `AW` bits of {first, second}, and bits above `AW` are ignored.
- R3: Each data byte goes to the buffer at the counter's low `PW` bits. Those bits then increment and wrap from the last page offset to offset 0, while the upper page bits stay fixed. More than 2^`PW` bytes overwrite the earlier ones.
- R4: A commit changes only the array bytes received in that transfer. All other bytes of the page keep their old values.
- R5: A stop in the data phase with at least one byte buffered raises `busy_o` on the next cycle for exactly `WR_CYCLES` cycles. During that time `in_ready_o` and `out_valid_o` are low and `sel_i`, `stop_i`, `in_valid_i` and `out_ready_i` have no effect.
- R6: `wp_i` is sampled at that stop. If it is high, the bytes are still accepted and the busy period still runs, but the array is not modified.
- R7: A stop before any data byte starts no busy period. The loaded address stays in the counter.
- R8: After a read-mode select, `out_valid_o` is high and `out_data_o` is the array byte at the counter. Each accepted transfer advances the counter by one, and the address after the last one is 0.
- R9: The counter persists across transfers. After a page write it points one past the last byte written, wrapped within the page.
- R10: When events share a cycle, a byte or read transfer in that cycle takes effect first. A select then wins over a stop, and a stop counts a byte accepted in its own cycle.
- R11: Back-pressure: while `out_valid_o` is high and `out_ready_i` is low, `out_data_o` holds. `in_ready_o` is high only in the two address phases and the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_i | input | 1 | Write protect, sampled at the committing stop |
| sel_i | input | 1 | Device-select byte matched (one-cycle pulse) |
| sel_rd_i | input | 1 | Read/write bit of that select, 1 = read |
| stop_i | input | 1 | Stop condition seen (one-cycle pulse) |
| in_valid_i | input | 1 | Received address/data byte valid |
| in_data_i | input | 8 | Received byte |
| in_ready_o | output | 1 | Block can take a byte |
| out_valid_o | output | 1 | Read byte available |
| out_data_o | output | 8 | Read byte |
| out_ready_i | input | 1 | Front end takes the read byte |
| busy_o | output | 1 | Internal write cycle running |

## Verification
Two pairs of events can fall in the same cycle. One is a stop together with the last data byte of a page write, and the other is a new select together with a stop or with an accepted read transfer. The bench drives each pair on one clock edge. It then judges the outcome at the ports: whether a busy period starts, which bytes a later read returns, and which address the read stream continues from. A behavioural model of the array and counter is compared with the outputs on every clock.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_AHI  = 3'd1,
    PH_ALO  = 3'd2,
    PH_DATA = 3'd3,
    PH_READ = 3'd4
  } phase_t;
endpackage

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [PW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [PW-1:0] ridx,
  output logic [7:0]    rdata,
  output logic          rhit,
  output logic          any
);
  localparam int PAGE = 1 << PW;

  logic [7:0]      store_q [PAGE];
  logic [PAGE-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mask_q <= '0;
    else if (clr)         mask_q <= '0;
    else if (we)          mask_q[widx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) store_q[widx] <= wdata;
  end

  assign rdata = store_q[ridx];
  assign rhit  = mask_q[ridx];
  assign any   = |mask_q;
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
  parameter int PW        = 6,
  parameter int WR_CYCLES = 625000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [PW-1:0] idx,
  output logic          idx_ok
);
  localparam int CW   = $clog2(WR_CYCLES + 1);
  localparam int PAGE = 1 << PW;

  logic [CW-1:0] el_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      el_q <= '0;
    end else if (busy) begin
      if (el_q == CW'(WR_CYCLES - 1)) busy <= 1'b0;
      el_q <= el_q + 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      el_q <= '0;
    end
  end

  assign idx    = el_q[PW-1:0];
  assign idx_ok = (el_q < CW'(PAGE));
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/eep_seq.sv
module eep_seq
  import eep_pkg::*;
#(
  parameter int AW        = 11,
  parameter int PW        = 6,
  parameter int WR_CYCLES = 625000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp_i,
  input  logic       sel_i,
  input  logic       sel_rd_i,
  input  logic       stop_i,
  input  logic       in_valid_i,
  input  logic [7:0] in_data_i,
  output logic       in_ready_o,
  output logic       out_valid_o,
  output logic [7:0] out_data_o,
  input  logic       out_ready_i,
  output logic       busy_o
);
  localparam int HW = AW - PW;

  phase_t        phase_q;
  logic [AW-1:0] ctr_q;
  logic [7:0]    hi_q;
  logic          wpl_q;

  logic          in_fire, out_fire, buf_we, buf_clr, buf_any, buf_hit, start;
  logic          tm_ok, arr_we;
  logic [PW-1:0] tm_idx;
  logic [7:0]    buf_rd, arr_rd;
  logic [15:0]   addr_full;
  logic [AW-1:0] waddr;

  assign in_ready_o  = !busy_o && (phase_q == PH_AHI || phase_q == PH_ALO || phase_q == PH_DATA);
  assign out_valid_o = !busy_o && (phase_q == PH_READ);
  assign in_fire     = in_valid_i && in_ready_o;
  assign out_fire    = out_valid_o && out_ready_i;
  assign buf_we      = in_fire && (phase_q == PH_DATA);
  assign buf_clr     = !busy_o && sel_i && !sel_rd_i;
  assign start       = !busy_o && !sel_i && stop_i && (phase_q == PH_DATA) && (buf_any || buf_we);
  assign addr_full   = {hi_q, in_data_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ctr_q   <= '0;
      hi_q    <= '0;
      wpl_q   <= 1'b0;
    end else if (!busy_o) begin
      if (in_fire) begin
        case (phase_q)
          PH_AHI: begin
            hi_q    <= in_data_i;
            phase_q <= PH_ALO;
          end
          PH_ALO: begin
            ctr_q   <= addr_full[AW-1:0];
            phase_q <= PH_DATA;
          end
          PH_DATA: ctr_q <= {ctr_q[AW-1:PW], ctr_q[PW-1:0] + 1'b1};
          default: ;
        endcase
      end
      if (out_fire) ctr_q <= ctr_q + 1'b1;
      if (sel_i)       phase_q <= sel_rd_i ? PH_READ : PH_AHI;
      else if (stop_i) phase_q <= PH_IDLE;
      if (start) wpl_q <= wp_i;
    end
  end

  eep_page_buf #(.PW(PW)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we),
    .widx(ctr_q[PW-1:0]), .wdata(in_data_i),
    .ridx(tm_idx), .rdata(buf_rd), .rhit(buf_hit), .any(buf_any)
  );

  eep_wr_timer #(.PW(PW), .WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy_o), .idx(tm_idx), .idx_ok(tm_ok)
  );

  assign arr_we = busy_o && tm_ok && buf_hit && !wpl_q;

  generate
    if (HW > 0) begin : g_paged
      assign waddr = {ctr_q[AW-1:PW], tm_idx};
    end else begin : g_onepage
      assign waddr = tm_idx[AW-1:0];
    end
  endgenerate

  eep_array #(.AW(AW)) u_arr (
    .clk(clk), .we(arr_we), .waddr(waddr), .wdata(buf_rd),
    .raddr(ctr_q), .rdata(arr_rd)
  );

  assign out_data_o = arr_rd;
endmodule

// File: rtl/eep_seq_chk.sv
module eep_seq_chk #(
  parameter int AW = 11,
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          in_ready_o,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic          in_valid_i,
  input logic          stop_i,
  input logic [2:0]    phase_q,
  input logic [AW-1:0] ctr_q,
  input logic          arr_we
);
  // R5: nothing is offered or taken while the write cycle runs
  p_quiet_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!in_ready_o && !out_valid_o));

  // R5: a busy period only ever follows a stop
  p_busy_from_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i));

  // R5: the array is written only inside a busy period
  p_commit_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy_o);

  // R3: data bytes never move the page bits
  p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o && phase_q == 3'd3) |=> (ctr_q[AW-1:PW] == $past(ctr_q[AW-1:PW])));

  // R8: each accepted read byte steps the counter by one across the array
  p_read_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i) |=> (ctr_q == AW'($past(ctr_q) + 1'b1)));
endmodule

bind eep_seq eep_seq_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .in_ready_o(in_ready_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .in_valid_i(in_valid_i),
  .stop_i(stop_i), .phase_q(phase_q), .ctr_q(ctr_q), .arr_we(arr_we)
);

// File: tb/sim_eep_seq.sv
module sim_eep_seq;
  localparam int AW = 9, PW = 6, WRC = 80;
  localparam int SIZE = 1 << AW, PAGE = 1 << PW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, wp = 1'b0, sel = 1'b0, sel_rd = 1'b0, stop = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, busy;
  logic [7:0] out_data;

  eep_seq #(.AW(AW), .PW(PW), .WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .wp_i(wp), .sel_i(sel), .sel_rd_i(sel_rd),
    .stop_i(stop), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_ready_i(out_ready), .busy_o(busy)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;

  function automatic void chk(logic [31:0] got, logic [31:0] exp, string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endfunction

  // behavioural reference: 0 idle, 1 addr hi, 2 addr lo, 3 data, 4 read
  int m_mem [SIZE];
  int m_buf [PAGE];
  bit m_msk [PAGE];
  int m_ctr, m_ph, m_hi, m_busy, m_bcnt, m_wpl;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctr = 0; m_ph = 0; m_hi = 0; m_busy = 0; m_bcnt = 0; m_wpl = 0;
      foreach (m_msk[i]) m_msk[i] = 0;
    end else if (m_busy != 0) begin
      m_bcnt--;
      if (m_bcnt == 0) begin
        m_busy = 0;
        if (m_wpl == 0)
          foreach (m_msk[k]) if (m_msk[k]) m_mem[(m_ctr / PAGE) * PAGE + k] = m_buf[k];
      end
    end else begin
      if (in_valid && m_ph >= 1 && m_ph <= 3) begin
        if (m_ph == 1) begin m_hi = in_data; m_ph = 2; end
        else if (m_ph == 2) begin m_ctr = ((m_hi * 256) + in_data) % SIZE; m_ph = 3; end
        else begin
          m_buf[m_ctr % PAGE] = in_data;
          m_msk[m_ctr % PAGE] = 1;
          m_ctr = (m_ctr / PAGE) * PAGE + ((m_ctr + 1) % PAGE);
        end
      end
      if (out_ready && m_ph == 4) m_ctr = (m_ctr + 1) % SIZE;
      if (sel) begin
        if (!sel_rd) begin
          m_ph = 1;
          foreach (m_msk[i]) m_msk[i] = 0;
        end else m_ph = 4;
      end else if (stop) begin
        if (m_ph == 3) begin
          bit anyb;
          anyb = 0;
          foreach (m_msk[i]) anyb |= m_msk[i];
          if (anyb) begin m_busy = 1; m_bcnt = WRC; m_wpl = wp; end
        end
        m_ph = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(32'(busy), 32'(m_busy), "R5 busy vs model");
      chk(32'(in_ready), 32'(m_busy == 0 && m_ph >= 1 && m_ph <= 3), "R11 in_ready vs model");
      chk(32'(out_valid), 32'(m_busy == 0 && m_ph == 4), "R8 out_valid vs model");
      if (m_busy == 0 && m_ph == 4) chk(32'(out_data), 32'(m_mem[m_ctr]), "R8 out_data vs model");
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  function automatic int fv(int a);
    return ((a / PAGE) * 13 + (a % PAGE) * 11) & 255;
  endfunction

  task automatic cyc(); @(negedge clk); #1; endtask
  task automatic do_sel(bit r); sel = 1; sel_rd = r; cyc(); sel = 0; sel_rd = 0; endtask
  task automatic do_byte(int b); in_valid = 1; in_data = 8'(b); cyc(); in_valid = 0; endtask
  task automatic do_stop(); stop = 1; cyc(); stop = 0; endtask
  task automatic set_addr(int a); do_sel(0); do_byte(a / 256); do_byte(a % 256); endtask
  task automatic wait_idle(); while (busy) cyc(); endtask
  task automatic write_run(int a, int n, int base);
    set_addr(a);
    for (int k = 0; k < n; k++) do_byte((base + k * 11) & 255);
    do_stop();
    wait_idle();
  endtask
  task automatic rd(int exp, string tag);
    chk(32'(out_valid), 32'd1, tag);
    chk(32'(out_data), 32'(exp), tag);
    out_ready = 1; cyc(); out_ready = 0;
  endtask

  initial begin
    cyc(); cyc();
    chk(32'(busy), 0, "R1 busy low");
    chk(32'(in_ready), 0, "R1 in_ready low");
    chk(32'(out_valid), 0, "R1 out_valid low");
    rst_n = 1; cyc();

    for (int p = 0; p < SIZE / PAGE; p++) write_run(p * PAGE, PAGE, p * 13);

    // R7 address-only, R8 wrap at array end
    set_addr(SIZE - 2); do_stop();
    chk(32'(busy), 0, "R7 no busy without data");
    do_sel(1);
    rd(fv(SIZE - 2), "R8 read"); rd(fv(SIZE - 1), "R8 read last");
    rd(fv(0), "R8 wrap to 0"); rd(fv(1), "R8 after wrap");
    do_stop();
    do_sel(1); rd(fv(2), "R9 current address"); do_stop();

    // R3 in-page wrap, R5 ignore while busy, R9 counter after write
    set_addr(2 * PAGE + 62);
    for (int k = 0; k < 4; k++) do_byte((200 + k * 11) & 255);
    do_stop();
    chk(32'(busy), 1, "R5 busy after stop");
    do_sel(1);
    chk(32'(out_valid), 0, "R5 select ignored while busy");
    wait_idle();
    chk(32'(out_valid), 0, "R5 select still ignored");
    do_sel(1); rd(fv(2 * PAGE + 2), "R9 one past last in page"); do_stop();
    set_addr(2 * PAGE + 60); do_sel(1);
    rd(fv(2 * PAGE + 60), "R4 untouched"); rd(fv(2 * PAGE + 61), "R4 untouched");
    rd(200, "R3 offset 62"); rd(211, "R3 offset 63"); do_stop();
    set_addr(2 * PAGE); do_sel(1);
    rd(222, "R3 wrapped to offset 0"); rd(233, "R3 offset 1"); rd(fv(2 * PAGE + 2), "R4 untouched");
    do_stop();

    // R3 overflow past a page
    write_run(3 * PAGE, 66, 5);
    do_sel(1); rd(27, "R9 counter after overflow"); rd(38, "R3 offset 3"); do_stop();
    set_addr(3 * PAGE); do_sel(1); rd(197, "R3 overwrite 0"); rd(208, "R3 overwrite 1"); do_stop();

    // R6 write protect
    wp = 1;
    set_addr(4 * PAGE); do_byte(99); do_byte(98); do_byte(97);
    chk(32'(in_ready), 1, "R6 bytes accepted");
    do_stop();
    chk(32'(busy), 1, "R6 busy despite protect");
    wp = 0;
    wait_idle();
    set_addr(4 * PAGE); do_sel(1);
    rd(fv(4 * PAGE), "R6 protected"); rd(fv(4 * PAGE + 1), "R6 protected"); do_stop();

    // R10 byte and stop in one cycle
    set_addr(5 * PAGE); do_byte(1);
    in_valid = 1; in_data = 77; stop = 1; cyc(); in_valid = 0; stop = 0;
    chk(32'(busy), 1, "R10 stop with byte");
    wait_idle();
    set_addr(5 * PAGE); do_sel(1); rd(1, "R10 first byte"); rd(77, "R10 same-cycle byte"); do_stop();

    // R10 select beats stop
    set_addr(5 * PAGE + 10); do_byte(5);
    sel = 1; sel_rd = 1; stop = 1; cyc(); sel = 0; sel_rd = 0; stop = 0;
    chk(32'(busy), 0, "R10 select over stop");
    rd(fv(5 * PAGE + 11), "R10 read after select");
    do_stop();
    set_addr(5 * PAGE + 10); do_sel(1);
    rd(fv(5 * PAGE + 10), "R10 no commit");
    out_ready = 1; sel = 1; sel_rd = 1; cyc(); out_ready = 0; sel = 0; sel_rd = 0;
    rd(fv(5 * PAGE + 12), "R10 transfer with select");
    do_stop();

    // R2 high bits ignored
    set_addr(16'hFE05); do_stop();
    do_sel(1); rd(fv(5), "R2 masked address");
    // R11 hold under back-pressure
    for (int k = 0; k < 3; k++) begin
      chk(32'(out_data), 32'(fv(6)), "R11 data held");
      chk(32'(in_ready), 0, "R11 in_ready low in read");
      cyc();
    end
    rd(fv(6), "R11 after hold");
    do_stop();

    // R1 counter cleared by reset
    rst_n = 0; cyc(); cyc(); rst_n = 1; cyc();
    do_sel(1); rd(fv(0), "R1 counter at 0"); do_stop();

    cyc();
    finish_run();
  end
endmodule